// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each request carries a 4-bit operation code, the accumulator, the X index register, a memory operand and the current status byte. The unit works out an 8-bit result, a new X value and a new status byte in combinational logic. It captures all three into an output register on the clock edge where the valid strobe is high.

Add, subtract and the logic operations produce a new accumulator. Compare and bit test return the accumulator unchanged. Increment, decrement, the shifts and the rotates work on the memory operand and return the modified byte. The combined AND-then-subtract operation leaves the accumulator alone and writes its difference to X.

The status byte uses C at bit 0, Z at bit 1, I at bit 2, D at bit 3, B at bit 4, an unused bit at bit 5, V at bit 6 and N at bit 7. Flags that an operation does not touch pass through unchanged. Decimal mode is not implemented.

Operation codes:

| Code | Operation |
|------|-----------|
| 0 | ADD (add with carry) |
| 1 | SUB (subtract with borrow) |
| 2 | CMP (compare) |
| 3 | ANDSUB ((A AND X) minus M, result to X) |
| 4 | BIT (bit test) |
| 5 | AND |
| 6 | OR |
| 7 | XOR |
| 8 | INC |
| 9 | DEC |
| 10 | SHL (shift left) |
| 11 | SHR (shift right) |
| 12 | ROL (rotate left) |
| 13 | ROR (rotate right) |
| 14, 15 | no operation |

The output stage has three named states:
- S_EMPTY: nothing has been captured since reset.
- S_FRESH: a capture happened on the last edge, and `out_valid` is high.
- S_STALE: the captured value is still held, but it is not new.

Transitions:
- capture: any state goes to S_FRESH when `in_valid` is high.
- age: S_FRESH goes to S_STALE when `in_valid` is low.
- idle: S_EMPTY and S_STALE stay where they are when `in_valid` is low.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) gives result (A + M + C) mod 256, and sets C to bit 8 of the 9-bit sum.
- R2: ADD sets V when A and M share a sign bit and the result's sign bit differs from A's; otherwise V is cleared.
- R3: SUB (code 1) gives (A - M - (1 - C)) mod 256. It sets C when no borrow occurred, and sets V when the signed difference leaves the range -128..127.
- R4: CMP (code 2) sets Z and N from the low byte of A - M and sets C when A >= M. It returns A unchanged and leaves V unchanged.
- R5: ANDSUB (code 3) writes ((A AND X) - M) mod 256 to X, with no carry in. It sets N, Z and C as CMP does. It returns A unchanged and leaves V unchanged. Every other code passes X through.
- R6: BIT (code 4) sets Z when (A AND M) is zero, copies M bit 7 into N and M bit 6 into V, returns A unchanged and leaves C unchanged.
- R7: AND, OR and XOR (codes 5, 6, 7) give the bitwise result of A and M, update N and Z, and leave C and V unchanged.
- R8: INC and DEC (codes 8, 9) give M + 1 and M - 1 modulo 256, and update only N and Z.
- R9: SHL (code 10) moves M bit 7 into C and shifts in 0. SHR (code 11) moves M bit 0 into C, shifts in 0, and so always clears N. Both update Z and N from the result and leave V unchanged.
- R10: ROL (code 12) shifts the old C into bit 0 and M bit 7 into C. ROR (code 13) shifts the old C into bit 7 and M bit 0 into C. Both update N and Z.
- R11: Status bits 2 to 5 pass through unchanged for every code. Codes 14 and 15 return A, X and the status byte unchanged.
- R12: Outputs change only on a clock edge where `in_valid` is high, and `out_valid` is high for exactly the cycle after such an edge. Reset clears `out_res`, `out_idx`, `out_st` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Capture strobe for the current request |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value |
| idx_in | input | 8 | X index register value |
| mem_in | input | 8 | Memory operand |
| st_in | input | 8 | Current status byte |
| out_valid | output | 1 | High for the one cycle after a capture |
| out_res | output | 8 | Registered result byte |
| out_idx | output | 8 | Registered X value |
| out_st | output | 8 | Registered status byte |

## Verification
The assertions assume the following about the inputs:
- `in_valid` is low throughout reset.
- All request inputs are stable at the clock edge.

Under these assumptions, each `$past` sample refers to the request that was actually captured.

The stimulus follows these assumptions:
- It drives every input on the falling edge.
- It holds `in_valid` low during reset.
- It spreads the random requests across all sixteen codes, so the no-operation codes also reach the checks.
- It interleaves idle cycles, so the hold and aging behaviour of the output stage is exercised.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;
    localparam int OPW = 4;

    // status byte bit positions
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FV = 6;
    localparam int FN = 7;

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_CMP    = 4'd2,
        OP_ANDSUB = 4'd3,
        OP_BIT    = 4'd4,
        OP_AND    = 4'd5,
        OP_OR     = 4'd6,
        OP_XOR    = 4'd7,
        OP_INC    = 4'd8,
        OP_DEC    = 4'd9,
        OP_SHL    = 4'd10,
        OP_SHR    = 4'd11,
        OP_ROL    = 4'd12,
        OP_ROR    = 4'd13,
        OP_NOP0   = 4'd14,
        OP_NOP1   = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_FRESH = 2'd1,
        S_STALE = 2'd2
    } stage_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    x,
    input  logic [DW-1:0]    m,
    input  logic [DW-1:0]    p,
    output logic [DW-1:0]    res,
    output logic [DW-1:0]    idx,
    output logic [DW-1:0]    st
);
    localparam int MSB = DW - 1;

    logic [DW:0] sum, dif, cmpd, axd;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, m} + {{DW{1'b0}}, p[FC]};
        dif  = {1'b0, a} - {1'b0, m} - {{DW{1'b0}}, ~p[FC]};
        cmpd = {1'b0, a} - {1'b0, m};
        axd  = {1'b0, a & x} - {1'b0, m};
    end

    always_comb begin
        res = a;
        idx = x;
        st  = p;
        unique case (op)
            OP_ADD: begin
                res    = sum[MSB:0];
                st[FC] = sum[DW];
                st[FV] = ~(a[MSB] ^ m[MSB]) & (a[MSB] ^ sum[MSB]);
                st[FZ] = (sum[MSB:0] == '0);
                st[FN] = sum[MSB];
            end
            OP_SUB: begin
                res    = dif[MSB:0];
                st[FC] = ~dif[DW];
                st[FV] = (a[MSB] ^ m[MSB]) & (a[MSB] ^ dif[MSB]);
                st[FZ] = (dif[MSB:0] == '0);
                st[FN] = dif[MSB];
            end
            OP_CMP: begin
                st[FC] = ~cmpd[DW];
                st[FZ] = (cmpd[MSB:0] == '0);
                st[FN] = cmpd[MSB];
            end
            OP_ANDSUB: begin
                idx    = axd[MSB:0];
                st[FC] = ~axd[DW];
                st[FZ] = (axd[MSB:0] == '0);
                st[FN] = axd[MSB];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    m,
    input  logic [DW-1:0]    p,
    output logic [DW-1:0]    res,
    output logic [DW-1:0]    st
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] val;
    logic          upd_nz;

    always_comb begin
        res    = a;
        st     = p;
        val    = a;
        upd_nz = 1'b0;
        unique case (op)
            OP_BIT: begin
                st[FZ] = ((a & m) == '0);
                st[FN] = m[MSB];
                st[FV] = m[MSB-1];
            end
            OP_AND: begin val = a & m; res = val; upd_nz = 1'b1; end
            OP_OR:  begin val = a | m; res = val; upd_nz = 1'b1; end
            OP_XOR: begin val = a ^ m; res = val; upd_nz = 1'b1; end
            OP_INC: begin val = m + 1'b1; res = val; upd_nz = 1'b1; end
            OP_DEC: begin val = m - 1'b1; res = val; upd_nz = 1'b1; end
            OP_SHL: begin
                val = {m[MSB-1:0], 1'b0}; res = val; upd_nz = 1'b1;
                st[FC] = m[MSB];
            end
            OP_SHR: begin
                val = {1'b0, m[MSB:1]}; res = val; upd_nz = 1'b1;
                st[FC] = m[0];
            end
            OP_ROL: begin
                val = {m[MSB-1:0], p[FC]}; res = val; upd_nz = 1'b1;
                st[FC] = m[MSB];
            end
            OP_ROR: begin
                val = {p[FC], m[MSB:1]}; res = val; upd_nz = 1'b1;
                st[FC] = m[0];
            end
            default: ;
        endcase
        if (upd_nz) begin
            st[FZ] = (val == '0);
            st[FN] = val[MSB];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPW-1:0]   op,
    input  logic [DW-1:0]    acc_in,
    input  logic [DW-1:0]    idx_in,
    input  logic [DW-1:0]    mem_in,
    input  logic [DW-1:0]    st_in,
    output logic             out_valid,
    output logic [DW-1:0]    out_res,
    output logic [DW-1:0]    out_idx,
    output logic [DW-1:0]    out_st
);
    alu_op_e opc;
    assign opc = alu_op_e'(op);

    logic [DW-1:0] ar_res, ar_idx, ar_st;
    logic [DW-1:0] lg_res, lg_st;
    logic [DW-1:0] nx_res, nx_idx, nx_st;
    logic          arith_sel;

    alu8_arith u_arith (
        .op(opc), .a(acc_in), .x(idx_in), .m(mem_in), .p(st_in),
        .res(ar_res), .idx(ar_idx), .st(ar_st)
    );

    alu8_logic u_logic (
        .op(opc), .a(acc_in), .m(mem_in), .p(st_in),
        .res(lg_res), .st(lg_st)
    );

    // codes below OP_BIT belong to the arithmetic group
    assign arith_sel = (op < OP_BIT);

    always_comb begin
        if (arith_sel) begin
            nx_res = ar_res;
            nx_idx = ar_idx;
            nx_st  = ar_st;
        end else begin
            nx_res = lg_res;
            nx_idx = idx_in;
            nx_st  = lg_st;
        end
    end

    stage_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_EMPTY: state_nx = in_valid ? S_FRESH : S_EMPTY;
            S_FRESH: state_nx = in_valid ? S_FRESH : S_STALE;
            S_STALE: state_nx = in_valid ? S_FRESH : S_STALE;
            default: state_nx = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_res <= '0;
            out_idx <= '0;
            out_st  <= '0;
        end else if (in_valid) begin
            out_res <= nx_res;
            out_idx <= nx_idx;
            out_st  <= nx_st;
        end
    end

    assign out_valid = (state == S_FRESH);

    assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_res) && $stable(out_idx) && $stable(out_st)));
    assert_mid_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_st[5:2] == $past(st_in[5:2]));
    assert_cmp_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CMP) |=> (out_res == $past(acc_in) && out_st[FV] == $past(st_in[FV])));
    assert_bit_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_BIT) |=> (out_st[FN] == $past(mem_in[DW-1]) && out_st[FV] == $past(mem_in[DW-2])));
    assert_shr_clears_n_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SHR) |=> !out_st[FN]);
    assert_idx_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_ANDSUB) |=> out_idx == $past(idx_in));
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] acc_in = '0, idx_in = '0, mem_in = '0, st_in = '0;
    logic out_valid;
    logic [7:0] out_res, out_idx, out_st;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .acc_in(acc_in), .idx_in(idx_in), .mem_in(mem_in), .st_in(st_in),
        .out_valid(out_valid), .out_res(out_res), .out_idx(out_idx), .out_st(out_st)
    );

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0: return "R1/R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6, 4'd7: return "R7";
            4'd8, 4'd9: return "R8";
            4'd10, 4'd11: return "R9";
            4'd12, 4'd13: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [7:0] setnz(input logic [7:0] s, input logic [7:0] v);
        logic [7:0] t;
        t = s;
        t[1] = (v == 8'h00);
        t[7] = v[7];
        return t;
    endfunction

    // returns {res, idx, status}
    function automatic logic [23:0] model(input logic [3:0] c, input logic [7:0] a,
            input logic [7:0] x, input logic [7:0] m, input logic [7:0] p);
        logic [7:0] r, xi, s;
        int u, sg, ci;
        r = a; xi = x; s = p; ci = int'(p[0]);
        case (c)
            4'd0: begin
                u = int'(a) + int'(m) + ci;
                sg = int'($signed(a)) + int'($signed(m)) + ci;
                r = u[7:0]; s[0] = (u > 255); s[6] = (sg > 127 || sg < -128);
                s = setnz(s, r);
            end
            4'd1: begin
                u = int'(a) - int'(m) - (1 - ci);
                sg = int'($signed(a)) - int'($signed(m)) - (1 - ci);
                r = u[7:0]; s[0] = (u >= 0); s[6] = (sg > 127 || sg < -128);
                s = setnz(s, r);
            end
            4'd2: begin
                u = int'(a) - int'(m);
                s[0] = (u >= 0); s = setnz(s, u[7:0]);
            end
            4'd3: begin
                u = int'(a & x) - int'(m);
                xi = u[7:0]; s[0] = (u >= 0); s = setnz(s, xi);
            end
            4'd4: begin
                s[1] = ((a & m) == 0); s[7] = m[7]; s[6] = m[6];
            end
            4'd5: begin r = a & m; s = setnz(s, r); end
            4'd6: begin r = a | m; s = setnz(s, r); end
            4'd7: begin r = a ^ m; s = setnz(s, r); end
            4'd8: begin u = (int'(m) + 1) % 256; r = u[7:0]; s = setnz(s, r); end
            4'd9: begin u = (int'(m) + 255) % 256; r = u[7:0]; s = setnz(s, r); end
            4'd10: begin u = int'(m) * 2; r = u[7:0]; s[0] = m[7]; s = setnz(s, r); end
            4'd11: begin u = int'(m) / 2; r = u[7:0]; s[0] = m[0]; s = setnz(s, r); end
            4'd12: begin u = int'(m) * 2 + ci; r = u[7:0]; s[0] = m[7]; s = setnz(s, r); end
            4'd13: begin u = int'(m) / 2 + ci * 128; r = u[7:0]; s[0] = m[0]; s = setnz(s, r); end
            default: ;
        endcase
        return {r, xi, s};
    endfunction

    task automatic check(input string rq, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s res/idx/st actual %h %h %h expected %h %h %h",
                     rq, got[23:16], got[15:8], got[7:0], exp[23:16], exp[15:8], exp[7:0]);
        end
    endtask

    task automatic run_op(input logic [3:0] c, input logic [7:0] a, input logic [7:0] x,
                          input logic [7:0] m, input logic [7:0] p, input bit idle_after);
        logic [23:0] exp;
        @(negedge clk);
        op = c; acc_in = a; idx_in = x; mem_in = m; st_in = p; in_valid = 1'b1;
        exp = model(c, a, x, m, p);
        @(negedge clk);
        in_valid = 1'b0;
        check(req_of(c), {out_res, out_idx, out_st}, exp);
        check("R12 valid", {23'd0, out_valid}, 24'd1);
        if (idle_after) begin
            // change inputs while not strobed: outputs must hold (R12)
            acc_in = ~a; mem_in = ~m; st_in = ~p; idx_in = ~x;
            @(negedge clk);
            check("R12 hold", {out_res, out_idx, out_st}, exp);
            check("R12 valid low", {23'd0, out_valid}, 24'd0);
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        check("R12 reset", {out_res, out_idx, out_st}, 24'd0);
        check("R12 reset valid", {23'd0, out_valid}, 24'd0);
        rst_n = 1'b1;
        // directed corners
        run_op(4'd0, 8'h50, 8'h00, 8'h50, 8'h00, 1'b1); // R2 overflow positive
        run_op(4'd0, 8'hFF, 8'h00, 8'h01, 8'h00, 1'b0); // R1 carry, zero
        run_op(4'd0, 8'h10, 8'h00, 8'h20, 8'h01, 1'b0); // R1 carry in
        run_op(4'd1, 8'h50, 8'h00, 8'hB0, 8'h01, 1'b0); // R3 overflow
        run_op(4'd1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0); // R3 borrow in
        run_op(4'd2, 8'h42, 8'h00, 8'h42, 8'h40, 1'b0); // R4 equal, V kept
        run_op(4'd2, 8'h10, 8'h00, 8'h20, 8'h41, 1'b1); // R4 less
        run_op(4'd3, 8'hF0, 8'h3C, 8'h10, 8'h40, 1'b1); // R5
        run_op(4'd3, 8'h0F, 8'hF0, 8'h01, 8'h01, 1'b0); // R5 borrow
        run_op(4'd4, 8'h00, 8'h00, 8'hC0, 8'h01, 1'b0); // R6
        run_op(4'd4, 8'h01, 8'h00, 8'h3F, 8'hC0, 1'b0); // R6
        run_op(4'd7, 8'hAA, 8'h00, 8'hAA, 8'hC1, 1'b0); // R7 zero
        run_op(4'd8, 8'h00, 8'h00, 8'hFF, 8'hC3, 1'b0); // R8 wrap
        run_op(4'd9, 8'h00, 8'h00, 8'h00, 8'h41, 1'b0); // R8 wrap
        run_op(4'd11, 8'h00, 8'h00, 8'h01, 8'h80, 1'b0); // R9
        run_op(4'd10, 8'h00, 8'h00, 8'h80, 8'h00, 1'b0); // R9
        run_op(4'd12, 8'h00, 8'h00, 8'h80, 8'h01, 1'b0); // R10
        run_op(4'd13, 8'h00, 8'h00, 8'h01, 8'h01, 1'b0); // R10
        run_op(4'd14, 8'h12, 8'h34, 8'h56, 8'hFF, 1'b1); // R11
        run_op(4'd15, 8'h9A, 8'hBC, 8'hDE, 8'h3C, 1'b0); // R11
        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            run_op(rv[3:0], 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), rv[4]);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule